// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Frame Reader

This block is the master end of a three-wire serial link to a delta-sigma converter that delivers 24-bit result frames. A `start` pulse makes it pull chip select low. It then watches the data line, where the converter places an in-band end-of-conversion level, before it generates any serial clock. When that level reads low, it clocks in the whole frame and releases chip select. It then checks the fixed-low status bit and decodes the sign/MSB pair into overrange and underrange flags. The result appears as a one-cycle `valid` pulse that carries a signed 21-bit value.

The serial clock rate comes from a divider parameter. The runtime input `irq_mode` selects one of two ways of waiting. With `irq_mode` high, chip select stays low and the data line is watched continuously, like an interrupt line. With `irq_mode` low, the line is polled by repeatedly pulsing chip select. Both waits are bounded by a system-clock timeout. When the timeout expires, the block releases the link and reports the event.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, and `valid` and `timeout` are low.
- R2: `sclk` idles low and is low whenever `cs_n` is high. The first rising `sclk` edge after chip select falls comes at least one divided period (2*HALF_DIV system cycles) after the fall. Clocking begins only at a divider tick where `miso` reads low.
- R3: In poll mode (`irq_mode`=0), a high end-of-conversion level at a check releases chip select for one divided period and then asserts it again. In interrupt mode (`irq_mode`=1), chip select stays low until the frame is read.
- R4: A frame takes exactly 24 rising `sclk` edges. `miso` is captured on each rising edge, first bit = frame bit 23. `cs_n` goes high together with the falling edge after the 24th rise.
- R5: After the frame, `valid` is high for exactly one cycle. When frame bits 21 (sign) and 20 (MSB) differ, `result` equals frame bits 20..0, read as two's complement.
- R6: When bits 21 and 20 are both 1, `ovr`=1, `unr`=0, and `result` is clamped to 21'h0FFFFF.
- R7: When bits 21 and 20 are both 0, `unr`=1, `ovr`=0, and `result` is clamped to 21'h100000.
- R8: `frame_err` with `valid` equals the captured frame bit 22, which must be 0. The result is reported either way.
- R9: If no frame has started TMO_CYC system cycles after `start`, `timeout` pulses for one cycle and `cs_n` returns high. No `valid` and no `sclk` edge follow.
- R10: A `start` pulse while a transfer is in progress is ignored. It produces no extra frame and no extra `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin one read |
| irq_mode | input | 1 | 1 = hold select low and watch the line, 0 = poll |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| valid | output | 1 | One-cycle pulse with a decoded frame |
| result | output | 21 | Signed result, clamped at the range limits |
| ovr | output | 1 | Input above positive full scale |
| unr | output | 1 | Input below negative full scale |
| frame_err | output | 1 | Fixed-low status bit read high |
| timeout | output | 1 | One-cycle pulse when waiting for the conversion ran out |

## Verification
The assertions assume that `rst_n` and `start` are synchronous to `clk`. They also assume that `miso` changes only on falling `sclk` edges or while the end-of-conversion level is being watched. This holds because the bench models the converter: it presents the busy level until a countdown expires and advances its bit pointer only on falling `sclk`. Random frames, busy times and wait modes stay below the timeout, except in the one directed case that checks the timeout.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_BITS = 24;
    localparam int DATA_BITS  = 21;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GAP,
        ST_SHIFT
    } rd_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] value;
        logic                 ovr;
        logic                 unr;
        logic                 ferr;
    } decode_t;

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (wrap)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
        tick = en && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adc_frame_decode.sv
module adc_frame_decode
    import adc_rd_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output decode_t               dec
);
    localparam int SIGN_POS  = DATA_BITS;
    localparam int MSB_POS   = DATA_BITS - 1;
    localparam int DUMMY_POS = DATA_BITS + 1;

    logic sign_bit, msb_bit;

    always_comb begin
        sign_bit = frame[SIGN_POS];
        msb_bit  = frame[MSB_POS];
        dec.ovr  = sign_bit && msb_bit;
        dec.unr  = !sign_bit && !msb_bit;
        dec.ferr = frame[DUMMY_POS];
        if (dec.ovr)
            dec.value = {1'b0, {(DATA_BITS-1){1'b1}}};
        else if (dec.unr)
            dec.value = {1'b1, {(DATA_BITS-1){1'b0}}};
        else
            dec.value = frame[DATA_BITS-1:0];
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int TMO_CYC  = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 irq_mode,
    input  logic                 miso,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 valid,
    output logic [DATA_BITS-1:0] result,
    output logic                 ovr,
    output logic                 unr,
    output logic                 frame_err,
    output logic                 timeout
);
    localparam int TW  = $clog2(TMO_CYC + 1);
    localparam int NBW = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        rd_state_e             st;
        logic                  cs_n;
        logic                  sclk;
        logic                  settled;
        logic [NBW-1:0]        nbits;
        logic [FRAME_BITS-1:0] sh;
        logic [TW-1:0]         tmo;
        logic                  valid;
        logic                  tmo_err;
        decode_t               out;
    } regs_t;

    regs_t   d, q;
    logic    tick;
    decode_t dec;

    adc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.st != ST_IDLE),
        .tick (tick)
    );

    adc_frame_decode u_dec (
        .frame(q.sh),
        .dec  (dec)
    );

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        d.tmo_err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_SETTLE;
                    d.cs_n    = 1'b0;
                    d.settled = 1'b0;
                    d.tmo     = '0;
                    d.nbits   = '0;
                end
            end
            ST_SETTLE: begin
                d.tmo = q.tmo + 1'b1;
                if (tick) begin
                    if (!q.settled) begin
                        d.settled = 1'b1;
                    end else if (!miso) begin
                        d.st    = ST_SHIFT;
                        d.sclk  = 1'b1;
                        d.sh    = {q.sh[FRAME_BITS-2:0], miso};
                        d.nbits = NBW'(1);
                    end else if (!irq_mode) begin
                        d.st      = ST_GAP;
                        d.cs_n    = 1'b1;
                        d.settled = 1'b0;
                    end
                end
            end
            ST_GAP: begin
                d.tmo = q.tmo + 1'b1;
                if (tick) begin
                    if (!q.settled) begin
                        d.settled = 1'b1;
                    end else begin
                        d.st      = ST_SETTLE;
                        d.cs_n    = 1'b0;
                        d.settled = 1'b0;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (q.sclk) begin
                        d.sclk = 1'b0;
                        if (q.nbits == NBW'(FRAME_BITS)) begin
                            d.st    = ST_IDLE;
                            d.cs_n  = 1'b1;
                            d.valid = 1'b1;
                            d.out   = dec;
                        end
                    end else begin
                        d.sclk  = 1'b1;
                        d.sh    = {q.sh[FRAME_BITS-2:0], miso};
                        d.nbits = q.nbits + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if ((q.st == ST_SETTLE || q.st == ST_GAP) &&
            q.tmo == TW'(TMO_CYC - 1) && d.st != ST_SHIFT) begin
            d.st      = ST_IDLE;
            d.cs_n    = 1'b1;
            d.sclk    = 1'b0;
            d.tmo_err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.cs_n    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n      = q.cs_n;
    assign sclk      = q.sclk;
    assign valid     = q.valid;
    assign result    = q.out.value;
    assign ovr       = q.out.ovr;
    assign unr       = q.out.unr;
    assign frame_err = q.out.ferr;
    assign timeout   = q.tmo_err;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                                 // R2
    AST_RISE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (!cs_n && !$past(cs_n)));                        // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);                                               // R5
    AST_OVR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ovr) |-> (result == {1'b0, {(DATA_BITS-1){1'b1}}} && !unr)); // R6
    AST_UNR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && unr) |-> (result == {1'b1, {(DATA_BITS-1){1'b0}}} && !ovr)); // R7
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!valid && cs_n && !sclk));                          // R9
    AST_VALID_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cs_n && !sclk));                                      // R4

endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
    localparam int HALF = 3;
    localparam int TMO  = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic irq_mode = 1'b0;
    logic miso;
    logic cs_n, sclk, valid, ovr, unr, frame_err, timeout;
    logic [20:0] result;

    adc_frame_reader #(.HALF_DIV(HALF), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .irq_mode(irq_mode),
        .miso(miso), .cs_n(cs_n), .sclk(sclk), .valid(valid),
        .result(result), .ovr(ovr), .unr(unr), .frame_err(frame_err),
        .timeout(timeout)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // converter model
    logic [23:0] frame = '0;
    int busy_left = 0;
    int fcnt = 0;
    int nrise = 0;
    int csrise = 0;
    int nvalid = 0;
    int t_csfall = 0;
    int first_gap = -1;

    always @(posedge clk) begin
        cyc++;
        if (busy_left > 0) busy_left--;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(negedge cs_n) begin
        fcnt = 0;
        t_csfall = cyc;
    end
    always @(posedge cs_n) csrise++;
    always @(negedge sclk) fcnt++;
    always @(posedge sclk) begin
        if (nrise == 0 && first_gap < 0) first_gap = cyc - t_csfall;
        nrise++;
    end
    always @(negedge clk) if (valid) nvalid++;

    always_comb begin
        if (cs_n)             miso = 1'b1;
        else if (fcnt == 0)   miso = (busy_left != 0);
        else if (fcnt >= 24)  miso = 1'b1;
        else                  miso = frame[23 - fcnt];
    end

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] exp_res(input logic [23:0] f);
        if (f[21] && f[20])        return 21'h0FFFFF;
        else if (!f[21] && !f[20]) return 21'h100000;
        else                       return f[20:0];
    endfunction

    task automatic run_read(input logic [23:0] f, input int busy,
                            input logic m, input logic extra_start);
        logic got;
        got = 1'b0;
        frame = f; busy_left = busy; irq_mode = m;
        nrise = 0; csrise = 0; nvalid = 0; first_gap = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            start = (extra_start && k == 40);
            if (valid || timeout) begin
                got = valid;
                break;
            end
        end
        start = 1'b0;
        chk(got && !timeout, "R9 no spurious timeout", {31'd0, got}, 32'd1);
        chk(result == exp_res(f), "R5/R6/R7 result", {11'd0, result}, {11'd0, exp_res(f)});
        chk(ovr == (f[21] && f[20]), "R6 ovr", {31'd0, ovr}, {31'd0, f[21] && f[20]});
        chk(unr == (!f[21] && !f[20]), "R7 unr", {31'd0, unr}, {31'd0, !f[21] && !f[20]});
        chk(frame_err == f[22], "R8 frame_err", {31'd0, frame_err}, {31'd0, f[22]});
        chk(nrise == 24, "R4 rising edges", nrise, 32'd24);
        chk(cs_n && !sclk, "R4 release", {30'd0, cs_n, sclk}, 32'h2);
        chk(first_gap >= 2 * HALF, "R2 settle", first_gap, 2 * HALF);
        if (m || busy == 0)
            chk(csrise == 1, "R3 select held", csrise, 32'd1);
        else if (busy > 8 * HALF)
            chk(csrise >= 2, "R3 poll release", csrise, 32'd2);
        repeat (30) @(negedge clk);
        chk(nvalid == 1, "R5 one valid", nvalid, 32'd1);
        if (extra_start)
            chk(cs_n && nrise == 24 && csrise == (m ? 1 : csrise),
                "R10 start ignored", nrise, 32'd24);
    endtask

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && valid == 1'b0 && timeout == 1'b0,
            "R1 reset state", {28'd0, cs_n, sclk, valid, timeout}, 32'h8);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 idle after reset",
            {30'd0, cs_n, sclk}, 32'h2);

        // directed corners
        run_read({3'b001, 21'h0FFFFF}, 0,   1'b1, 1'b0); // R5 largest positive
        run_read({3'b000, 21'h100000}, 50,  1'b0, 1'b0); // R5 most negative
        run_read({3'b001, 21'h000000}, 90,  1'b1, 1'b0); // R5 zero
        run_read({3'b001, 21'h1ABCDE}, 120, 1'b0, 1'b0); // R6 overrange
        run_read({3'b000, 21'h012345}, 70,  1'b1, 1'b0); // R7 underrange
        run_read({3'b011, 21'h0F0F0F}, 10,  1'b0, 1'b0); // R8 dummy high
        run_read({3'b001, 21'h055555}, 30,  1'b1, 1'b1); // R10 start during read

        // R9 timeout: conversion never ends
        begin
            int lat;
            logic saw;
            lat = 0; saw = 1'b0;
            busy_left = 1000000; irq_mode = 1'b0;
            nrise = 0; nvalid = 0;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            lat = 1;
            for (int k = 0; k < TMO + 50; k++) begin
                if (timeout) begin saw = 1'b1; break; end
                @(negedge clk);
                lat++;
            end
            chk(saw, "R9 timeout raised", {31'd0, saw}, 32'd1);
            chk(lat >= TMO && lat <= TMO + 2, "R9 timeout latency", lat, TMO + 1);
            chk(cs_n && nrise == 0 && nvalid == 0, "R9 release, no frame",
                nrise, 32'd0);
            busy_left = 0;
            repeat (10) @(negedge clk);
        end

        // random frames
        for (int i = 0; i < 40; i++) begin
            logic [23:0] f;
            f = {1'b0, ($urandom % 8 == 0), $urandom(), 21'd0} ;
            f[21:0] = 22'($urandom());
            run_read(f, int'($urandom % 200), 1'(($urandom % 2)), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule